// File: doc/BRIEF.md
# Compressed-Test DRAM Core

This block models the test-mode logic of a four-bit-wide DRAM whose storage is built as eight-bit words. Each external access picks one nibble of a stored word. The three active-low strobes (row, column, write) are sampled on a clock. A RAS fall in which CAS and the write strobe were already low switches the core into a compressed test mode. In that mode a single data bit is written to all eight cells of a word. A read returns one pass/fail flag that says whether all eight cells of the word agree, with the other output lanes held high.

Any refresh-style cycle returns the core to normal mode. This covers a CAS-first cycle without a write, a row strobe that opens and closes with no column access, and a hidden refresh in which CAS stays low across a new RAS fall. Read data is registered and held past the rising CAS edge. It is released by a write access, or once both strobes are sampled high.

Top module: `edo_tm_core`

## Requirements
- R1: While reset is high, and after it, the mode is normal (`test_mode` = 0) and `dq_oe` = 0.
- R2: A sampled RAS fall with CAS low enters test mode if `we_n` was low both in that sample and in the previous one. `test_mode` reads 1 from the next cycle.
- R3: A sampled RAS fall with CAS low leaves test mode if `we_n` was high in that sample or in the previous one. This includes a write strobe that falls only together with RAS.
- R4: A RAS-low period that closes with no CAS fall and was not CAS-first leaves test mode.
- R5: Hidden refresh: CAS held low after a read while RAS rises and falls again leaves test mode, and the read data stays driven.
- R6: In normal mode a write stores `dq_in` into bits 3:0 of the word when column bit 0 is 0, and into bits 7:4 when it is 1. The other nibble is left unchanged.
- R7: In normal mode a read returns the nibble selected by column bit 0. `dq_oe` is 1 and `dq_out` is valid from the cycle after the CAS fall is sampled.
- R8: In test mode a write stores `dq_in[0]` into all eight bits of the word. `dq_in[3:1]` have no effect.
- R9: In test mode a read drives `dq_out[2:0]` = 111. `dq_out[3]` is 1 if all eight bits of the word are equal and 0 otherwise.
- R10: In test mode column bit 0 is ignored: both column codes that differ only in bit 0 reach the same word.
- R11: `dq_oe` stays 1 across a CAS rise while RAS is low. It drops after a write access, or after a cycle in which both RAS and CAS are sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | IO_W | Write data |
| dq_out | output | IO_W | Read data or test result |
| dq_oe | output | 1 | Read data is driven |
| test_mode | output | 1 | Compressed test mode active |

## Verification
The bench builds the core with its default parameters: a four-bit address and four data lanes. This gives a 128-word array that is small enough for every word in use to be written before it is read. Both nibble codes of one word can be reached with a single change of column bit 0. A short vector table takes the core through entry, every exit route, writes in both modes and pass and fail compares. Directed sequences then cover the page-mode hold of read data, a write strobe that falls too late, a hidden refresh and a reset taken while in test mode.

// File: rtl/edo_tm_pkg.sv
package edo_tm_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_TEST   = 1'b1
    } mode_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    typedef enum logic [1:0] {
        FALL_NONE,
        FALL_ROW,
        FALL_CBR,
        FALL_WCBR
    } fall_kind_t;

    // Classify what a RAS edge between two samples means.
    function automatic fall_kind_t classify_fall(strobe_t prev, strobe_t cur);
        fall_kind_t k;
        k = FALL_NONE;
        if (prev.ras_n && !cur.ras_n) begin
            if (cur.cas_n)
                k = FALL_ROW;
            else if (!cur.we_n && !prev.we_n)
                k = FALL_WCBR;
            else
                k = FALL_CBR;
        end
        return k;
    endfunction

endpackage

// File: rtl/edo_tm_seq.sv
module edo_tm_seq
    import edo_tm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output mode_t             mode,
    output logic              acc_vld,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_row,
    output logic [ADDR_W-1:0] acc_col
);

    strobe_t             cur_s;
    strobe_t             prev_s;
    fall_kind_t          fall_k;
    logic                cbr_cyc;
    logic                cas_seen;
    logic [ADDR_W-1:0]   row_q;
    mode_t               mode_q;
    logic                cas_fall;
    logic                ras_held;
    logic                ras_rise;

    assign cur_s    = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n};
    assign fall_k   = classify_fall(prev_s, cur_s);
    assign cas_fall = prev_s.cas_n && !cas_n;
    assign ras_held = !prev_s.ras_n && !ras_n;
    assign ras_rise = !prev_s.ras_n && ras_n;

    assign acc_vld  = cas_fall && ras_held && !cbr_cyc;
    assign acc_we   = !we_n;
    assign acc_row  = row_q;
    assign acc_col  = addr;
    assign mode     = mode_q;

    always_ff @(posedge clk) begin
        prev_s <= cur_s;
        if (rst) begin
            mode_q   <= MODE_NORMAL;
            cbr_cyc  <= 1'b0;
            cas_seen <= 1'b0;
            row_q    <= '0;
        end else begin
            unique case (fall_k)
                FALL_ROW: begin
                    row_q    <= addr;
                    cbr_cyc  <= 1'b0;
                    cas_seen <= 1'b0;
                end
                FALL_CBR: begin
                    cbr_cyc <= 1'b1;
                    mode_q  <= MODE_NORMAL;
                end
                FALL_WCBR: begin
                    cbr_cyc <= 1'b1;
                    mode_q  <= MODE_TEST;
                end
                default: ;
            endcase
            if (acc_vld)
                cas_seen <= 1'b1;
            if (ras_rise && !cbr_cyc && !cas_seen)
                mode_q <= MODE_NORMAL;
        end
    end

endmodule

// File: rtl/edo_tm_io.sv
module edo_tm_io
    import edo_tm_pkg::*;
#(
    parameter int IO_W = 4
) (
    input  mode_t               mode,
    input  logic                nib_sel,
    input  logic [IO_W-1:0]     din,
    input  logic [2*IO_W-1:0]   rword,
    output logic [2*IO_W-1:0]   wmask,
    output logic [2*IO_W-1:0]   wdata,
    output logic [IO_W-1:0]     rres
);

    localparam int WORD_W = 2 * IO_W;

    logic lanes_agree;

    assign lanes_agree = (rword == '0) || (rword == '1);

    always_comb begin
        if (mode == MODE_TEST) begin
            wmask = '1;
            wdata = {WORD_W{din[0]}};
            rres  = {lanes_agree, {(IO_W-1){1'b1}}};
        end else begin
            wmask = nib_sel ? {{IO_W{1'b1}}, {IO_W{1'b0}}}
                            : {{IO_W{1'b0}}, {IO_W{1'b1}}};
            wdata = {din, din};
            rres  = nib_sel ? rword[WORD_W-1:IO_W] : rword[IO_W-1:0];
        end
    end

endmodule

// File: rtl/edo_tm_array.sv
module edo_tm_array #(
    parameter int WORD_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wmask,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        for (int b = 0; b < WORD_W; b++) begin
            if (wr_en && wmask[b])
                mem[addr][b] <= wdata[b];
        end
    end

endmodule

// File: rtl/edo_tm_core.sv
module edo_tm_core
    import edo_tm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int IO_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [IO_W-1:0]   dq_in,
    output logic [IO_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              test_mode
);

    localparam int WORD_W = 2 * IO_W;
    localparam int AW     = 2 * ADDR_W - 1;

    mode_t             mode;
    logic              acc_vld;
    logic              acc_we;
    logic [ADDR_W-1:0] acc_row;
    logic [ADDR_W-1:0] acc_col;
    logic [AW-1:0]     word_addr;
    logic [WORD_W-1:0] wmask;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] rword;
    logic [IO_W-1:0]   rres;
    logic [IO_W-1:0]   dout_q;
    logic              oe_q;

    assign word_addr = {acc_row, acc_col[ADDR_W-1:1]};
    assign test_mode = (mode == MODE_TEST);
    assign dq_out    = dout_q;
    assign dq_oe     = oe_q;

    edo_tm_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .mode    (mode),
        .acc_vld (acc_vld),
        .acc_we  (acc_we),
        .acc_row (acc_row),
        .acc_col (acc_col)
    );

    edo_tm_io #(.IO_W(IO_W)) u_io (
        .mode    (mode),
        .nib_sel (acc_col[0]),
        .din     (dq_in),
        .rword   (rword),
        .wmask   (wmask),
        .wdata   (wdata),
        .rres    (rres)
    );

    edo_tm_array #(.WORD_W(WORD_W), .AW(AW)) u_arr (
        .clk   (clk),
        .wr_en (acc_vld && acc_we),
        .addr  (word_addr),
        .wmask (wmask),
        .wdata (wdata),
        .rdata (rword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            oe_q   <= 1'b0;
        end else if (acc_vld) begin
            if (acc_we) begin
                oe_q <= 1'b0;
            end else begin
                oe_q   <= 1'b1;
                dout_q <= rres;
            end
        end else if (ras_n && cas_n) begin
            oe_q <= 1'b0;
        end
    end

endmodule

// File: rtl/edo_tm_chk.sv
module edo_tm_chk #(
    parameter int IO_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic [IO_W-1:0] dq_out,
    input logic            dq_oe,
    input logic            test_mode,
    input logic            acc_vld,
    input logic            acc_we
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!test_mode && !dq_oe));

    a_r2_wcbr_enter: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n && !we_n && ($past(we_n) == 1'b0)) |=> test_mode);

    a_r3_cbr_leave: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n && (we_n || $past(we_n))) |=> !test_mode);

    a_r2_mode_moves_on_ras: assert property (@(posedge clk) disable iff (rst)
        (!$fell(ras_n) && !$rose(ras_n)) |=> $stable(test_mode));

    a_r7_read_drives: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !acc_we) |=> dq_oe);

    a_r9_test_lanes_high: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && !acc_we && test_mode) |=> (dq_out[IO_W-2:0] == '1));

    a_r11_write_release: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_we) |=> !dq_oe);

    a_r11_idle_release: assert property (@(posedge clk) disable iff (rst)
        (ras_n && cas_n) |=> !dq_oe);

endmodule

bind edo_tm_core edo_tm_chk #(.IO_W(IO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .test_mode (test_mode),
    .acc_vld   (acc_vld),
    .acc_we    (acc_we)
);

// File: tb/sim_edo_tm_core.sv
module sim_edo_tm_core;

    localparam int ADDR_W = 4;
    localparam int IO_W   = 4;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_WCBR = 3'd2;
    localparam logic [2:0] OP_CBR  = 3'd3;
    localparam logic [2:0] OP_RONL = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] row;
        logic [3:0] col;
        logic [3:0] d;
        logic [3:0] e;
        logic       m;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{OP_WR,   4'd3, 4'd4, 4'hA, 4'h0, 1'b0},  // R6 lower nibble
        '{OP_WR,   4'd3, 4'd5, 4'h5, 4'h0, 1'b0},  // R6 upper nibble
        '{OP_RD,   4'd3, 4'd4, 4'h0, 4'hA, 1'b0},  // R7
        '{OP_RD,   4'd3, 4'd5, 4'h0, 4'h5, 1'b0},  // R7
        '{OP_WR,   4'd3, 4'd5, 4'hC, 4'h0, 1'b0},  // R6
        '{OP_RD,   4'd3, 4'd4, 4'h0, 4'hA, 1'b0},  // R6 other nibble kept
        '{OP_RD,   4'd3, 4'd5, 4'h0, 4'hC, 1'b0},  // R7
        '{OP_WCBR, 4'd0, 4'd0, 4'h0, 4'h0, 1'b1},  // R2
        '{OP_WR,   4'd1, 4'd2, 4'hE, 4'h0, 1'b1},  // R8 upper lanes ignored
        '{OP_RD,   4'd1, 4'd2, 4'h0, 4'hF, 1'b1},  // R9 pass
        '{OP_RD,   4'd1, 4'd3, 4'h0, 4'hF, 1'b1},  // R10
        '{OP_RD,   4'd3, 4'd4, 4'h0, 4'h7, 1'b1},  // R9 fail on 0xCA
        '{OP_WR,   4'd2, 4'd7, 4'h1, 4'h0, 1'b1},  // R8 ones
        '{OP_RD,   4'd2, 4'd6, 4'h0, 4'hF, 1'b1},  // R10
        '{OP_CBR,  4'd0, 4'd0, 4'h0, 4'h0, 1'b0},  // R3
        '{OP_RD,   4'd2, 4'd6, 4'h0, 4'hF, 1'b0},  // R8 seen in normal mode
        '{OP_RD,   4'd2, 4'd7, 4'h0, 4'hF, 1'b0},  // R8
        '{OP_RD,   4'd1, 4'd3, 4'h0, 4'h0, 1'b0},  // R8 zeros
        '{OP_WCBR, 4'd0, 4'd0, 4'h0, 4'h0, 1'b1},  // R2
        '{OP_RONL, 4'd5, 4'd0, 4'h0, 4'h0, 1'b0},  // R4
        '{OP_WR,   4'd6, 4'd0, 4'h9, 4'h0, 1'b0},  // R6
        '{OP_RD,   4'd6, 4'd0, 4'h0, 4'h9, 1'b0},  // R7
        '{OP_WCBR, 4'd0, 4'd0, 4'h0, 4'h0, 1'b1},  // R2
        '{OP_WR,   4'd6, 4'd1, 4'h6, 4'h0, 1'b1},  // R8 bit0 = 0
        '{OP_RD,   4'd6, 4'd0, 4'h0, 4'hF, 1'b1},  // R9 R10
        '{OP_CBR,  4'd0, 4'd0, 4'h0, 4'h0, 1'b0},  // R3
        '{OP_RD,   4'd6, 4'd0, 4'h0, 4'h0, 1'b0}   // R8 all zero
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
    logic [ADDR_W-1:0] addr;
    logic [IO_W-1:0]   dq_in;
    logic [IO_W-1:0]   dq_out;
    logic              dq_oe;
    logic              test_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    edo_tm_core #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .test_mode (test_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_wr(input logic [3:0] row, input logic [3:0] col, input logic [3:0] d);
        ras_n = 1'b0; addr = row;
        step();
        addr = col; dq_in = d; we_n = 1'b0; cas_n = 1'b0;
        step();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        step();
    endtask

    task automatic do_rd(input logic [3:0] row, input logic [3:0] col,
                         output logic [3:0] o, output logic oe);
        ras_n = 1'b0; addr = row;
        step();
        addr = col; cas_n = 1'b0;
        step();
        o = dq_out; oe = dq_oe;
        ras_n = 1'b1; cas_n = 1'b1;
        step();
    endtask

    task automatic do_wcbr();
        cas_n = 1'b0; we_n = 1'b0;
        step();
        ras_n = 1'b0;
        step();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        step();
    endtask

    task automatic do_cbr();
        cas_n = 1'b0;
        step();
        ras_n = 1'b0;
        step();
        ras_n = 1'b1; cas_n = 1'b1;
        step();
    endtask

    task automatic do_ronly(input logic [3:0] row);
        ras_n = 1'b0; addr = row;
        step();
        step();
        ras_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        logic [3:0] o;
        logic       oe;
        rst = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        addr = '0; dq_in = '0;
        repeat (3) step();
        check("R1 mode in reset", {7'd0, test_mode}, 8'd0);
        rst = 1'b0;
        step();
        check("R1 mode after reset", {7'd0, test_mode}, 8'd0);
        check("R1 oe after reset", {7'd0, dq_oe}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            case (v.op)
                OP_WR:   do_wr(v.row, v.col, v.d);
                OP_RD: begin
                    do_rd(v.row, v.col, o, oe);
                    check(v.m ? "R9 test read" : "R7 normal read", {4'd0, o}, {4'd0, v.e});
                    check("R7 oe during read", {7'd0, oe}, 8'd1);
                end
                OP_WCBR: do_wcbr();
                OP_CBR:  do_cbr();
                default: do_ronly(v.row);
            endcase
            step();
            case (v.op)
                OP_WCBR: check("R2 entry", {7'd0, test_mode}, {7'd0, v.m});
                OP_CBR:  check("R3 refresh exit", {7'd0, test_mode}, {7'd0, v.m});
                OP_RONL: check("R4 ras-only exit", {7'd0, test_mode}, {7'd0, v.m});
                default: check("R2 mode kept", {7'd0, test_mode}, {7'd0, v.m});
            endcase
            if (v.op == OP_RD)
                check("R11 oe released when idle", {7'd0, dq_oe}, 8'd0);
        end

        // Page cycle: read, CAS up, write in the same row (R7, R11)
        ras_n = 1'b0; addr = 4'd3;
        step();
        addr = 4'd4; cas_n = 1'b0;
        step();
        check("R7 page read", {4'd0, dq_out}, 8'h0A);
        cas_n = 1'b1;
        step();
        check("R11 oe held over CAS rise", {7'd0, dq_oe}, 8'd1);
        addr = 4'd5; dq_in = 4'h3; we_n = 1'b0; cas_n = 1'b0;
        step();
        check("R11 oe dropped by write", {7'd0, dq_oe}, 8'd0);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        step();
        step();
        do_rd(4'd3, 4'd5, o, oe);
        check("R6 page write upper nibble", {4'd0, o}, 8'h03);
        step();

        // Write strobe falls only with RAS: refresh, not entry (R3)
        do_wcbr();
        step();
        check("R2 entry before late-WE cycle", {7'd0, test_mode}, 8'd1);
        cas_n = 1'b0;
        step();
        ras_n = 1'b0; we_n = 1'b0;
        step();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        step();
        check("R3 late WE leaves test mode", {7'd0, test_mode}, 8'd0);

        // Hidden refresh after a test read (R5)
        do_wcbr();
        step();
        do_wr(4'd1, 4'd2, 4'h1);
        step();
        ras_n = 1'b0; addr = 4'd1;
        step();
        addr = 4'd2; cas_n = 1'b0;
        step();
        check("R9 test read before hidden refresh", {4'd0, dq_out}, 8'h0F);
        ras_n = 1'b1;
        step();
        ras_n = 1'b0;
        step();
        check("R5 hidden refresh exit", {7'd0, test_mode}, 8'd0);
        check("R5 data still driven", {7'd0, dq_oe}, 8'd1);
        check("R5 data held", {4'd0, dq_out}, 8'h0F);
        ras_n = 1'b1; cas_n = 1'b1;
        step();
        step();
        check("R11 oe released after hidden refresh", {7'd0, dq_oe}, 8'd0);

        // Reset while in test mode (R1)
        do_wcbr();
        step();
        check("R2 entry before reset", {7'd0, test_mode}, 8'd1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check("R1 reset clears mode", {7'd0, test_mode}, 8'd0);
        check("R1 reset clears oe", {7'd0, dq_oe}, 8'd0);

        report();
    end

endmodule